// File: doc/BRIEF.md
# Legacy and Message Interrupt Aggregator

This block merges the four legacy level-sensitive interrupt lines of a PCI Express root port and the inbound message-signalled interrupt writes into a single interrupt request towards the host processor. Legacy lines are latched into a shared status word. Software clears a latched bit by writing 1 to it, and an enable word selects which status bits may raise the output. Message writes that land inside a programmable address window are captured, in arrival order, into a small queue.

The queue is drained one message at a time through a register interface. A pending flag shows that the queue holds something. Two registers show the captured address of the oldest message. Reading the data register returns the payload of the oldest message and removes it. By convention a sender uses vector number v with payload v at address base + 4·v, so a 64-byte window holds sixteen vectors. The queue's non-empty state also appears as a summary bit in the shared status word, which lets one enable bit gate all message traffic.

The register port is a plain single-cycle interface. Writes take effect on the clock edge. Read data is combinational from the current state, and a read of the data register pops the queue on that edge.

Top module: `irqagg_top`

## Requirements
- R1: After reset every register reads 0, the queue is empty and `irq_o` is low.
- R2: A legacy line `intx_i[k]` that is high at a clock edge (with no write to the status word, address 0) sets status bit 5+k at that edge. The bit reads back at bits 8..5 of address 0.
- R3: A write to address 0 clears each legacy status bit whose write-data bit is 1 and leaves the others unchanged. If the line is still high, the bit sets again at the following edge, so a read in the cycle right after the clearing write returns 0.
- R4: The enable word (address 1) stores only bits 3 and 8..5 and reads other bits as 0. `irq_o` is high exactly when some bit of the status word AND the enable word is 1.
- R5: Status bit 3 is 1 exactly while the message queue is non-empty. Writes to address 0 do not change it.
- R6: A message is accepted when the capture enable (address 5, bit 0) is 1 and base ≤ address < base + span. Base is {address 3, address 2} and span is address 4. Accepted messages leave the queue in arrival order. All tests use register values from before the clock edge.
- R7: A message that arrives while capture is disabled, or whose address lies outside the window, is dropped and leaves the queue unchanged.
- R8: A read of address 7 returns the payload of the oldest message and removes it at that edge. Addresses 8 and 9 return the low and high words of the oldest message's address. With the queue empty all three read 0 and a read of address 7 changes nothing.
- R9: An accepted message that arrives when the queue holds DEPTH entries (before the edge) is dropped and sets the overflow flag (address 6, bit 1). The flag stays set until a write of 1 to that bit. A new overflow in the same cycle as the clearing write keeps the flag set.
- R10: Address 6 bit 0 reads 1 exactly while at least one message waits in the queue.
- R11: Addresses 2 to 5 read back the values written: bit 0 only for address 5, and all 32 bits for the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| intx_i | input | 4 | Legacy interrupt lines A to D, active high |
| msg_valid_i | input | 1 | Inbound message write strobe |
| msg_addr_i | input | 64 | Address of the inbound message write |
| msg_data_i | input | 32 | Payload of the inbound message write |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops on address 7) |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default queue depth of four entries. This makes a full queue, a dropped message and a collision between setting and clearing the overflow flag reachable within a handful of messages. The window is placed above the 32-bit boundary, so the carry into the high word of the address compare is exercised. Addresses just below the base, at the top vector, and one word past the window check the edges of the window test.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int N_INTX      = 4;
  localparam int INTX_LSB    = 5;
  localparam int MSI_SUM_BIT = 3;
  localparam int OVF_BIT     = 1;

  localparam logic [31:0] EN_MASK =
    (32'((1 << N_INTX) - 1) << INTX_LSB) | (32'd1 << MSI_SUM_BIT);

  typedef enum logic [3:0] {
    RA_STAT     = 4'd0,
    RA_EN       = 4'd1,
    RA_BASE_LO  = 4'd2,
    RA_BASE_HI  = 4'd3,
    RA_SPAN     = 4'd4,
    RA_CTL      = 4'd5,
    RA_MSTAT    = 4'd6,
    RA_DATA     = 4'd7,
    RA_HADDR_LO = 4'd8,
    RA_HADDR_HI = 4'd9
  } reg_addr_e;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msi_msg_t;

  // unsigned offset test: base <= a < base + span without a 65-bit adder
  function automatic logic in_window(input logic [63:0] a,
                                     input logic [63:0] base,
                                     input logic [31:0] span);
    logic [63:0] off;
    off = a - base;
    return off < {32'd0, span};
  endfunction

  function automatic logic [31:0] build_status(input logic [N_INTX-1:0] intx,
                                               input logic msi_pending);
    return (32'(intx) << INTX_LSB) | (32'(msi_pending) << MSI_SUM_BIT);
  endfunction

endpackage

// File: rtl/irqagg_intx_latch.sv
module irqagg_intx_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] stat_o
);

  logic [N-1:0] stat_nxt;

  for (genvar g = 0; g < N; g++) begin : g_bit
    // a clearing write wins its cycle; a held line re-latches one edge later
    assign stat_nxt[g] = clr_wr_i ? (stat_o[g] & ~clr_mask_i[g])
                                  : (stat_o[g] | line_i[g]);

    // R2
    intx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (line_i[g] && !clr_wr_i) |=> stat_o[g]);

    // R3
    intx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr_i && clr_mask_i[g]) |=> !stat_o[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_o <= '0;
    else        stat_o <= stat_nxt;
  end

endmodule

// File: rtl/irqagg_msi_fifo.sv
module irqagg_msi_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 96
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic [W-1:0]                 wdata_i,
  output logic [W-1:0]                 head_o,
  output logic                         full_o,
  output logic                         empty_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (count_o == CW'(DEPTH));
  assign empty_o = (count_o == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  // R9
  fifo_no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && full_o));

  // R8
  fifo_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> empty_o);

  // R6
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH));

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  intx_i,
  input  logic        msg_valid_i,
  input  logic [63:0] msg_addr_i,
  input  logic [31:0] msg_data_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);

  localparam int MW = $bits(msi_msg_t);
  localparam int CW = $clog2(DEPTH + 1);

  logic [31:0]       en_q, span_q;
  logic [63:0]       base_q;
  logic              msi_on_q, ovf_q;
  logic [N_INTX-1:0] intx_stat;
  logic              stat_wr, ovf_clr, ovf_hit;
  logic              msg_in_win, msg_accept, msg_push, msg_pop;
  logic              q_full, q_empty;
  logic [CW-1:0]     q_count;
  msi_msg_t          q_head, q_head_vis, q_in;
  logic [31:0]       stat_word;

  // register-port events
  assign stat_wr = reg_wr_i && (reg_addr_i == RA_STAT);
  assign ovf_clr = reg_wr_i && (reg_addr_i == RA_MSTAT) && reg_wdata_i[OVF_BIT];
  assign msg_pop = reg_rd_i && (reg_addr_i == RA_DATA);

  // message capture events
  assign msg_in_win = in_window(msg_addr_i, base_q, span_q);
  assign msg_accept = msg_valid_i && msi_on_q && msg_in_win;
  assign msg_push   = msg_accept && !q_full;
  assign ovf_hit    = msg_accept && q_full;
  assign q_in       = '{addr: msg_addr_i, data: msg_data_i};

  irqagg_intx_latch #(.N(N_INTX)) u_intx (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (intx_i),
    .clr_wr_i   (stat_wr),
    .clr_mask_i (reg_wdata_i[INTX_LSB +: N_INTX]),
    .stat_o     (intx_stat)
  );

  irqagg_msi_fifo #(.DEPTH(DEPTH), .W(MW)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (msg_push),
    .pop_i   (msg_pop),
    .wdata_i (q_in),
    .head_o  (q_head),
    .full_o  (q_full),
    .empty_o (q_empty),
    .count_o (q_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      base_q   <= '0;
      span_q   <= '0;
      msi_on_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (reg_wr_i) begin
        case (reg_addr_i)
          RA_EN:      en_q          <= reg_wdata_i & EN_MASK;
          RA_BASE_LO: base_q[31:0]  <= reg_wdata_i;
          RA_BASE_HI: base_q[63:32] <= reg_wdata_i;
          RA_SPAN:    span_q        <= reg_wdata_i;
          RA_CTL:     msi_on_q      <= reg_wdata_i[0];
          default:    ;
        endcase
      end
      // a fresh overflow outranks a clear in the same cycle
      if (ovf_hit)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  assign stat_word  = build_status(intx_stat, !q_empty);
  assign irq_o      = |(stat_word & en_q);
  assign q_head_vis = q_empty ? '0 : q_head;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      case (reg_addr_i)
        RA_STAT:     reg_rdata_o = stat_word;
        RA_EN:       reg_rdata_o = en_q;
        RA_BASE_LO:  reg_rdata_o = base_q[31:0];
        RA_BASE_HI:  reg_rdata_o = base_q[63:32];
        RA_SPAN:     reg_rdata_o = span_q;
        RA_CTL:      reg_rdata_o = {31'd0, msi_on_q};
        RA_MSTAT:    reg_rdata_o = {30'd0, ovf_q, !q_empty};
        RA_DATA:     reg_rdata_o = q_head_vis.data;
        RA_HADDR_LO: reg_rdata_o = q_head_vis.addr[31:0];
        RA_HADDR_HI: reg_rdata_o = q_head_vis.addr[63:32];
        default:     reg_rdata_o = '0;
      endcase
    end
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);

  // R7
  msi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_i && !msi_on_q) |=> (q_count <= $past(q_count)));

  // R4
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o);

  // R5
  msi_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_push && !msg_pop) |=> !q_empty);

endmodule

// File: tb/tb_irqagg_top.sv
`timescale 1ns/100ps
module tb_irqagg_top;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx_i = '0;
  logic        msg_valid_i = 1'b0;
  logic [63:0] msg_addr_i = '0;
  logic [31:0] msg_data_i = '0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] last_rd;

  // reference state
  logic [3:0]  m_lst;
  logic [31:0] m_en, m_blo, m_bhi, m_span;
  logic        m_on, m_ovf;
  logic [63:0] mq_addr [$];
  logic [31:0] mq_data [$];

  localparam logic [63:0] BASE = 64'h0000_0001_0000_1000;

  always #2.5 clk = ~clk;

  irqagg_top #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .intx_i(intx_i), .msg_valid_i(msg_valid_i),
    .msg_addr_i(msg_addr_i), .msg_data_i(msg_data_i), .reg_wr_i(reg_wr_i),
    .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input logic ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] a);
    logic ne;
    ne = (mq_data.size() != 0);
    case (a)
      4'd0: return {23'd0, m_lst, 1'b0, ne, 3'd0};
      4'd1: return m_en;
      4'd2: return m_blo;
      4'd3: return m_bhi;
      4'd4: return m_span;
      4'd5: return {31'd0, m_on};
      4'd6: return {30'd0, m_ovf, ne};
      4'd7: return ne ? mq_data[0] : 32'd0;
      4'd8: return ne ? mq_addr[0][31:0] : 32'd0;
      4'd9: return ne ? mq_addr[0][63:32] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic m_irq();
    logic [31:0] s;
    s = {23'd0, m_lst, 1'b0, (mq_data.size() != 0), 3'd0};
    return |(s & m_en);
  endfunction

  // one clock: drive at the falling edge, update the model at the rising edge,
  // compare the interrupt output at the next falling edge
  task automatic step(input logic wr, input logic rd, input logic [3:0] a,
                      input logic [31:0] wd, input logic [3:0] lines,
                      input logic mv, input logic [63:0] ma,
                      input logic [31:0] md, input string req);
    logic pop, acc, full;
    logic [63:0] off;
    reg_wr_i = wr; reg_rd_i = rd; reg_addr_i = a; reg_wdata_i = wd;
    intx_i = lines; msg_valid_i = mv; msg_addr_i = ma; msg_data_i = md;
    #1;
    if (rd) begin
      last_rd = reg_rdata_o;
      chk(reg_rdata_o == m_read(a), req, 64'(reg_rdata_o), 64'(m_read(a)));
    end
    @(posedge clk);
    pop  = rd && (a == 4'd7) && (mq_data.size() != 0);
    full = (mq_data.size() == DEPTH);
    off  = ma - {m_bhi, m_blo};
    acc  = mv && m_on && (off < {32'd0, m_span});
    if (wr && a == 4'd0) m_lst = m_lst & ~wd[8:5];
    else                 m_lst = m_lst | lines;
    if (wr) begin
      case (a)
        4'd1: m_en   = wd & 32'h0000_01E8;
        4'd2: m_blo  = wd;
        4'd3: m_bhi  = wd;
        4'd4: m_span = wd;
        4'd5: m_on   = wd[0];
        default: ;
      endcase
    end
    if (acc && full)             m_ovf = 1'b1;
    else if (wr && a == 4'd6 && wd[1]) m_ovf = 1'b0;
    if (pop) begin
      void'(mq_data.pop_front());
      void'(mq_addr.pop_front());
    end
    if (acc && !full) begin
      mq_data.push_back(md);
      mq_addr.push_back(ma);
    end
    @(negedge clk);
    chk(irq_o == m_irq(), {req, " irq"}, 64'(irq_o), 64'(m_irq()));
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d,
                      input logic [3:0] lines, input string req);
    step(1'b1, 1'b0, a, d, lines, 1'b0, '0, '0, req);
  endtask

  task automatic rreg(input logic [3:0] a, input logic [3:0] lines,
                      input logic [31:0] exp, input string req);
    step(1'b0, 1'b1, a, '0, lines, 1'b0, '0, '0, req);
    chk(last_rd == exp, {req, " literal"}, 64'(last_rd), 64'(exp));
  endtask

  task automatic send(input logic [63:0] ma, input logic [31:0] md,
                      input logic [3:0] lines, input string req);
    step(1'b0, 1'b0, 4'd0, '0, lines, 1'b1, ma, md, req);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    m_lst = '0; m_en = '0; m_blo = '0; m_bhi = '0; m_span = '0;
    m_on = 1'b0; m_ovf = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(irq_o == 1'b0, "R1 irq", 64'(irq_o), 64'd0);
    for (int a = 0; a < 10; a++) rreg(4'(a), 4'h0, 32'd0, "R1");

    // R4 enable mask
    wreg(4'd1, 32'hFFFF_FFFF, 4'h0, "R4");
    rreg(4'd1, 4'h0, 32'h0000_01E8, "R4");

    // R2 latch, R3 clear and re-latch
    step(1'b0, 1'b0, 4'd0, '0, 4'b0010, 1'b0, '0, '0, "R2");
    rreg(4'd0, 4'b0010, 32'h0000_0040, "R2");
    wreg(4'd0, 32'h0000_0040, 4'b0010, "R3");
    rreg(4'd0, 4'b0010, 32'h0000_0000, "R3");
    rreg(4'd0, 4'b0000, 32'h0000_0040, "R3");
    wreg(4'd0, 32'h0000_0040, 4'b0000, "R3");
    rreg(4'd0, 4'b0000, 32'h0000_0000, "R3");
    step(1'b0, 1'b0, 4'd0, '0, 4'b1001, 1'b0, '0, '0, "R2");
    wreg(4'd0, 32'h0000_0020, 4'b0000, "R3");
    rreg(4'd0, 4'b0000, 32'h0000_0100, "R3");
    wreg(4'd1, 32'h0000_0008, 4'b0000, "R4");
    chk(irq_o == 1'b0, "R4 masked", 64'(irq_o), 64'd0);
    wreg(4'd0, 32'hFFFF_FFFF, 4'b0000, "R3");

    // R11 configuration readback
    wreg(4'd2, BASE[31:0], 4'h0, "R11");
    wreg(4'd3, BASE[63:32], 4'h0, "R11");
    wreg(4'd4, 32'h0000_0040, 4'h0, "R11");
    rreg(4'd2, 4'h0, 32'h0000_1000, "R11");
    rreg(4'd3, 4'h0, 32'h0000_0001, "R11");
    rreg(4'd4, 4'h0, 32'h0000_0040, "R11");

    // R7 disabled capture drops
    send(BASE + 64'd8, 32'd2, 4'h0, "R7");
    rreg(4'd6, 4'h0, 32'd0, "R7");
    wreg(4'd5, 32'hFFFF_FFFF, 4'h0, "R11");
    rreg(4'd5, 4'h0, 32'd1, "R11");

    // R6 capture and order, R7 window edges
    send(BASE + 64'd8, 32'd2, 4'h0, "R6");
    send(BASE + 64'h40, 32'd16, 4'h0, "R7");
    send(BASE - 64'd4, 32'd99, 4'h0, "R7");
    send(BASE + 64'h3C, 32'd15, 4'h0, "R6");
    rreg(4'd6, 4'h0, 32'd1, "R10");
    rreg(4'd0, 4'h0, 32'h0000_0008, "R5");
    wreg(4'd0, 32'h0000_0008, 4'h0, "R5");
    rreg(4'd0, 4'h0, 32'h0000_0008, "R5");
    chk(irq_o == 1'b1, "R4 msi irq", 64'(irq_o), 64'd1);
    rreg(4'd8, 4'h0, 32'h0000_1008, "R8");
    rreg(4'd9, 4'h0, 32'h0000_0001, "R8");
    rreg(4'd7, 4'h0, 32'd2, "R8");
    rreg(4'd8, 4'h0, 32'h0000_103C, "R8");
    rreg(4'd7, 4'h0, 32'd15, "R8");
    rreg(4'd7, 4'h0, 32'd0, "R8");
    rreg(4'd6, 4'h0, 32'd0, "R10");

    // R9 overflow, set beats clear
    for (int v = 0; v < DEPTH + 1; v++)
      send(BASE + 64'(v * 4), 32'(v), 4'h0, "R9");
    rreg(4'd6, 4'h0, 32'd3, "R9");
    step(1'b1, 1'b0, 4'd6, 32'd2, 4'h0, 1'b1, BASE + 64'd4, 32'd1, "R9");
    rreg(4'd6, 4'h0, 32'd3, "R9");
    wreg(4'd6, 32'd2, 4'h0, "R9");
    rreg(4'd6, 4'h0, 32'd1, "R9");
    for (int v = 0; v < DEPTH; v++) rreg(4'd7, 4'h0, 32'(v), "R9");

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      logic [1:0] kind;
      kind = 2'($urandom_range(0, 3));
      a = 4'($urandom_range(0, 10));
      case (kind)
        2'd0: step(1'b0, 1'b1, a, '0, 4'($urandom), 1'b0, '0, '0, "R6 mix");
        2'd1: step(1'b0, 1'b1, 4'd7, '0, 4'($urandom), 1'b1,
                   BASE + 64'($urandom_range(0, 23)) * 4 - 64'd16,
                   $urandom, "R8 mix");
        2'd2: step(1'b1, 1'b0, (a < 4'd2) ? a : 4'd6, $urandom, 4'($urandom),
                   1'b1, BASE + 64'($urandom_range(0, 19)) * 4, $urandom,
                   "R9 mix");
        default: step(1'b0, 1'b0, 4'd0, '0, 4'($urandom), 1'b1,
                      BASE + 64'($urandom_range(0, 17)) * 4, $urandom,
                      "R6 mix");
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule